// File: doc/BRIEF.md
# Descriptor-Ring Copy Engine

This block is a single-channel copy engine. It moves data from producer buffers into consumer buffers. Two circular descriptor rings in shared memory drive the work: a source ring that a producer fills with buffers to send, and a destination ring that a consumer stocks with empty receive buffers. Software sets each ring's base address, slot count and write index through a small register port. The engine walks the source ring from its own read index up to the producer's write index. It copies each buffer word by word into the current receive buffer, then records the result in the receive descriptor.

A source descriptor may carry a gather flag, which means "more follows". Consecutive gather descriptors, together with the first descriptor without the flag, are packed back to back into one receive buffer and finish with a single completion. Completion is shown in two places: a non-zero byte count written into the receive descriptor, and then an advanced destination read index with a pending copy-complete flag. A descriptor longer than the programmed maximum is never consumed: the engine waits at it and raises an error flag. It also waits while no receive buffer is available. All memory traffic uses one 32-bit request/response port with one access outstanding.

Top module: `ce_copy_engine`

## Requirements
- R1: After reset both read indices read 0, the pending register reads 0, `irq` is low, the slot-count registers read 16, the maximum length reads 0xFFFF, and each watermark register reads high mark 16 in bits [31:16] with low mark 0 in bits [15:0].
- R2: A descriptor is two little-endian words at base + 8*index: word 0 is the buffer address, and word 1 holds the byte count in [15:0] and the flags in [31:16]. The flag bits are: bit 0 gather, bit 1 byte swap, bits [15:2] metadata. For a single non-gather descriptor the engine copies ceil(count/4) words into the receive buffer and writes the receive descriptor's word 1 as {metadata, swap, 0, count}. It then advances both read indices by one and sets pending bit 0.
- R3: Gather descriptors and the first following non-gather descriptor fill one receive buffer contiguously. Only one receive descriptor is consumed. Its count is the sum of the segment counts, and its metadata and swap bit come from the last segment. Every gather segment except the last must have a count that is a multiple of 4.
- R4: When a source descriptor's swap flag is set, each 32-bit word it contributes is written with its byte order reversed.
- R5: Each read index advances modulo the slot count, which is a power of two, and wraps from count-1 to 0. Write indices are masked with count-1.
- R6: While the destination read index equals the destination write index, no new receive buffer is opened. The source descriptor waiting for it is not consumed, and its copy resumes once a buffer is posted.
- R7: A source descriptor whose count exceeds the maximum length is not consumed, and pending bit 1 is set. The copy proceeds once the maximum is raised to at least the count.
- R8: Writing a one to a pending bit clears it. `irq` is high exactly while a pending bit and its enable bit (bit 0 copy-complete, bit 1 length error) are both set.
- R9: The receive descriptor's count word is written to memory before the destination read index changes.

Register word offsets on `cfg_addr`: 0 source base, 1 source slot count, 2 source write index, 3 source read index (read only), 4 destination base, 5 destination slot count, 6 destination write index, 7 destination read index (read only), 8 maximum length, 9 interrupt enables, 10 pending (write one to clear), 11 source watermarks, 12 destination watermarks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| irq | output | 1 | Interrupt: an enabled pending bit is set |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The hardest condition to reach is the engine waiting on a descriptor it has already fetched. This happens either because the receive ring is empty or because the count is over the limit, and in both cases the descriptor must stay unconsumed. The bench builds this by posting a source descriptor while the receive write index equals its read index, or by posting an 80-byte descriptor against a 64-byte limit. It watches the read indices and the untouched receive count for a stretch of cycles, then releases the engine by posting a buffer or raising the limit. The ring slot count is set to four, so the directed sequence wraps both rings. Every index advance it polls is also checked against the count word already in memory.

// File: rtl/ce_pkg.sv
// Package: shared constants and types of the descriptor-ring copy engine.
// Assumes the descriptor format of two little-endian 32-bit words.
package ce_pkg;
    localparam int LEN_W      = 16;  // descriptor byte-count field
    localparam int FLAG_W     = 16;  // descriptor flags field
    localparam int FLG_GATHER = 0;
    localparam int FLG_SWAP   = 1;

    localparam logic [3:0] RG_SRC_BASE = 4'd0;
    localparam logic [3:0] RG_SRC_CNT  = 4'd1;
    localparam logic [3:0] RG_SRC_WR   = 4'd2;
    localparam logic [3:0] RG_SRC_RD   = 4'd3;
    localparam logic [3:0] RG_DST_BASE = 4'd4;
    localparam logic [3:0] RG_DST_CNT  = 4'd5;
    localparam logic [3:0] RG_DST_WR   = 4'd6;
    localparam logic [3:0] RG_DST_RD   = 4'd7;
    localparam logic [3:0] RG_MAXLEN   = 4'd8;
    localparam logic [3:0] RG_INT_EN   = 4'd9;
    localparam logic [3:0] RG_INT_PND  = 4'd10;
    localparam logic [3:0] RG_SRC_MARK = 4'd11;
    localparam logic [3:0] RG_DST_MARK = 4'd12;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SD0, ST_SD1, ST_CHECK, ST_DD0,
        ST_RDW, ST_WRW, ST_SEG, ST_WB
    } eng_state_t;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/ce_ring_idx.sv
// Module: hardware read index of one descriptor ring.
// Advances by one modulo the ring size; assumes the size is a power of two
// and is not changed while the ring holds outstanding descriptors.
module ce_ring_idx #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] mask,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    // Index register: cleared by reset, stepped and wrapped on adv.
    always_ff @(posedge clk) begin
        if (!rst_n)   idx <= '0;
        else if (adv) idx <= (idx + 1'b1) & mask;
    end

    // R5
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx & ~mask) == '0);
endmodule

// File: rtl/ce_regs.sv
// Module: register file of the copy engine.
// Holds ring configuration, limits, enables and the write-one-to-clear
// pending bits; read data is a combinational mux on cfg_addr.
module ce_regs
    import ce_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int DEF_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              done_evt,
    input  logic              err_evt,
    input  logic [IDX_W-1:0]  src_rd,
    input  logic [IDX_W-1:0]  dst_rd,
    output logic [31:0]       src_base,
    output logic [31:0]       dst_base,
    output logic [IDX_W-1:0]  src_mask,
    output logic [IDX_W-1:0]  dst_mask,
    output logic [IDX_W-1:0]  src_wr_m,
    output logic [IDX_W-1:0]  dst_wr_m,
    output logic [LEN_W-1:0]  maxlen,
    output logic              irq
);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [31:0] MARK_RST = {16'(DEF_ENTRIES), 16'h0000};

    logic [31:0]      base_q [2];
    logic [CNT_W-1:0] cnt_q  [2];
    logic [IDX_W-1:0] wr_q   [2];
    logic [31:0]      mark_q [2];
    logic [IDX_W-1:0] mask_w [2];
    logic [1:0]       int_en;
    logic [1:0]       int_pnd;

    for (genvar r = 0; r < 2; r++) begin : g_ring
        localparam logic [3:0] OFS = 4'(4 * r);
        // Per-ring configuration registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[r] <= '0;
                cnt_q[r]  <= CNT_W'(DEF_ENTRIES);
                wr_q[r]   <= '0;
                mark_q[r] <= MARK_RST;
            end else if (cfg_wr) begin
                if (cfg_addr == OFS + RG_SRC_BASE) base_q[r] <= cfg_wdata;
                if (cfg_addr == OFS + RG_SRC_CNT)  cnt_q[r]  <= cfg_wdata[CNT_W-1:0];
                if (cfg_addr == OFS + RG_SRC_WR)   wr_q[r]   <= cfg_wdata[IDX_W-1:0];
                if (cfg_addr == RG_SRC_MARK + 4'(r)) mark_q[r] <= cfg_wdata;
            end
        end
        assign mask_w[r] = IDX_W'(cnt_q[r] - 1'b1);
    end

    // Limit and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maxlen <= '1;
            int_en <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == RG_MAXLEN) maxlen <= cfg_wdata[LEN_W-1:0];
            if (cfg_addr == RG_INT_EN) int_en <= cfg_wdata[1:0];
        end
    end

    // Pending bits: set by events, cleared by writing ones; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) int_pnd <= '0;
        else begin
            int_pnd <= (int_pnd & ~((cfg_wr && cfg_addr == RG_INT_PND) ? cfg_wdata[1:0] : 2'b00))
                       | {err_evt, done_evt};
        end
    end

    // Read-back mux.
    always_comb begin
        case (cfg_addr)
            RG_SRC_BASE: cfg_rdata = base_q[0];
            RG_SRC_CNT:  cfg_rdata = 32'(cnt_q[0]);
            RG_SRC_WR:   cfg_rdata = 32'(wr_q[0]);
            RG_SRC_RD:   cfg_rdata = 32'(src_rd);
            RG_DST_BASE: cfg_rdata = base_q[1];
            RG_DST_CNT:  cfg_rdata = 32'(cnt_q[1]);
            RG_DST_WR:   cfg_rdata = 32'(wr_q[1]);
            RG_DST_RD:   cfg_rdata = 32'(dst_rd);
            RG_MAXLEN:   cfg_rdata = 32'(maxlen);
            RG_INT_EN:   cfg_rdata = 32'(int_en);
            RG_INT_PND:  cfg_rdata = 32'(int_pnd);
            RG_SRC_MARK: cfg_rdata = mark_q[0];
            RG_DST_MARK: cfg_rdata = mark_q[1];
            default:     cfg_rdata = '0;
        endcase
    end

    assign src_base = base_q[0];
    assign dst_base = base_q[1];
    assign src_mask = mask_w[0];
    assign dst_mask = mask_w[1];
    assign src_wr_m = wr_q[0] & mask_w[0];
    assign dst_wr_m = wr_q[1] & mask_w[1];
    assign irq      = |(int_pnd & int_en);

    // R8
    done_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_pnd[0]) |-> $past(done_evt));
    // R7
    err_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_pnd[1]) |-> $past(err_evt));
endmodule

// File: rtl/ce_engine.sv
// Module: transfer sequencer of the copy engine.
// Fetches source descriptors, opens a receive buffer, copies words with
// optional byte reversal, merges gather chains and writes the receive
// descriptor back. One memory access outstanding; mem_req is held until
// mem_ack. Assumes word-aligned buffers.
module ce_engine
    import ce_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      src_base,
    input  logic [31:0]      dst_base,
    input  logic [IDX_W-1:0] src_rd,
    input  logic [IDX_W-1:0] dst_rd,
    input  logic [IDX_W-1:0] src_wr_m,
    input  logic [IDX_W-1:0] dst_wr_m,
    input  logic [LEN_W-1:0] maxlen,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             src_adv,
    output logic             dst_adv,
    output logic             done_evt,
    output logic             err_evt
);
    localparam int PAD_W = 32 - IDX_W - 3;

    eng_state_t        state;
    logic [31:0]       sptr, dptr, data_q;
    logic [LEN_W-1:0]  cur_len, acc;
    logic [FLAG_W-1:0] cur_flags;
    logic [LEN_W-2:0]  words_left;
    logic              open_q;
    logic [LEN_W:0]    len_p3;
    logic [31:0]       src_desc, dst_desc;
    logic              too_long, dst_avail;

    assign src_desc  = src_base + {{PAD_W{1'b0}}, src_rd, 3'b000};
    assign dst_desc  = dst_base + {{PAD_W{1'b0}}, dst_rd, 3'b000};
    assign len_p3    = {1'b0, mem_rdata[LEN_W-1:0]} + (LEN_W+1)'(3);
    assign too_long  = cur_len > maxlen;
    assign dst_avail = dst_rd != dst_wr_m;

    // Sequencer: one state per memory access, plus check and segment end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sptr       <= '0;
            dptr       <= '0;
            data_q     <= '0;
            cur_len    <= '0;
            cur_flags  <= '0;
            words_left <= '0;
            acc        <= '0;
            open_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE:  if (src_rd != src_wr_m) state <= ST_SD0;
                ST_SD0:   if (mem_ack) begin
                              sptr  <= mem_rdata;
                              state <= ST_SD1;
                          end
                ST_SD1:   if (mem_ack) begin
                              cur_len    <= mem_rdata[LEN_W-1:0];
                              cur_flags  <= mem_rdata[31:16];
                              words_left <= len_p3[LEN_W:2];
                              state      <= ST_CHECK;
                          end
                ST_CHECK: if (!too_long) begin
                              if (!open_q) begin
                                  if (dst_avail) state <= ST_DD0;
                              end else if (words_left == '0) state <= ST_SEG;
                              else state <= ST_RDW;
                          end
                ST_DD0:   if (mem_ack) begin
                              dptr   <= mem_rdata;
                              acc    <= '0;
                              open_q <= 1'b1;
                              state  <= ST_CHECK;
                          end
                ST_RDW:   if (mem_ack) begin
                              data_q <= cur_flags[FLG_SWAP] ? swap32(mem_rdata) : mem_rdata;
                              sptr   <= sptr + 32'd4;
                              state  <= ST_WRW;
                          end
                ST_WRW:   if (mem_ack) begin
                              dptr       <= dptr + 32'd4;
                              words_left <= words_left - 1'b1;
                              state      <= (words_left == (LEN_W-1)'(1)) ? ST_SEG : ST_RDW;
                          end
                ST_SEG:   begin
                              acc   <= acc + cur_len;
                              state <= cur_flags[FLG_GATHER] ? ST_IDLE : ST_WB;
                          end
                ST_WB:    if (mem_ack) begin
                              open_q <= 1'b0;
                              state  <= ST_IDLE;
                          end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Memory request decode from the current state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_SD0: mem_addr = src_desc;
            ST_SD1: mem_addr = src_desc + 32'd4;
            ST_DD0: mem_addr = dst_desc;
            ST_RDW: mem_addr = sptr;
            ST_WRW: begin
                mem_we    = 1'b1;
                mem_addr  = dptr;
                mem_wdata = data_q;
            end
            ST_WB: begin
                mem_we    = 1'b1;
                mem_addr  = dst_desc + 32'd4;
                mem_wdata = {cur_flags[FLAG_W-1:2], cur_flags[FLG_SWAP], 1'b0, acc};
            end
            default: mem_req = 1'b0;
        endcase
    end

    assign src_adv  = (state == ST_SEG);
    assign dst_adv  = (state == ST_WB) && mem_ack;
    assign done_evt = dst_adv;
    assign err_evt  = (state == ST_CHECK) && too_long;

    // R7
    no_oversize_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_adv |-> (cur_len <= maxlen));
    // R6
    no_empty_dst_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DD0) |-> dst_avail);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: rtl/ce_copy_engine.sv
// Module: top of the single-channel descriptor-ring copy engine.
// Joins the register file, the two ring read indices and the sequencer.
module ce_copy_engine
    import ce_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int DEF_ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    logic [IDX_W-1:0] ring_rd   [2];
    logic [IDX_W-1:0] ring_mask [2];
    logic [1:0]       ring_adv;
    logic [31:0]      src_base, dst_base;
    logic [IDX_W-1:0] src_wr_m, dst_wr_m;
    logic [LEN_W-1:0] maxlen;
    logic             done_evt, err_evt, src_adv, dst_adv;

    ce_regs #(.IDX_W(IDX_W), .DEF_ENTRIES(DEF_ENTRIES)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .done_evt(done_evt), .err_evt(err_evt),
        .src_rd(ring_rd[0]), .dst_rd(ring_rd[1]),
        .src_base(src_base), .dst_base(dst_base),
        .src_mask(ring_mask[0]), .dst_mask(ring_mask[1]),
        .src_wr_m(src_wr_m), .dst_wr_m(dst_wr_m),
        .maxlen(maxlen), .irq(irq)
    );

    assign ring_adv = {dst_adv, src_adv};

    for (genvar g = 0; g < 2; g++) begin : g_idx
        ce_ring_idx #(.IDX_W(IDX_W)) u_idx (
            .clk(clk), .rst_n(rst_n), .mask(ring_mask[g]),
            .adv(ring_adv[g]), .idx(ring_rd[g])
        );
    end

    ce_engine #(.IDX_W(IDX_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .src_base(src_base), .dst_base(dst_base),
        .src_rd(ring_rd[0]), .dst_rd(ring_rd[1]),
        .src_wr_m(src_wr_m), .dst_wr_m(dst_wr_m), .maxlen(maxlen),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .src_adv(src_adv), .dst_adv(dst_adv),
        .done_evt(done_evt), .err_evt(err_evt)
    );

    // R9
    wb_before_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ring_rd[1]) |-> $past(mem_req && mem_we && mem_ack));
endmodule

// File: tb/ce_copy_engine_test.sv
// Directed bench for the copy engine with a one-cycle-latency memory model.
module ce_copy_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tb_we = 1'b0;
    logic [31:0] tb_addr = '0, tb_data = '0;
    logic [31:0] mem [0:1023];
    int          n_tests = 0, n_fail = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    ce_copy_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: serves one request a cycle after it appears; bench backdoor.
    always @(posedge clk) begin
        if (tb_we) mem[tb_addr[11:2]] <= tb_data;
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end else mem_ack <= 1'b0;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); cfg_addr = a; #1 v = cfg_rdata;
    endtask

    task automatic src_desc(input int slot, input logic [31:0] buf_a,
                            input logic [15:0] len, input logic [15:0] flg);
        poke(32'h100 + 32'(8 * slot), buf_a);
        poke(32'h104 + 32'(8 * slot), {flg, len});
    endtask

    task automatic dst_desc(input int slot, input logic [31:0] buf_a);
        poke(32'h200 + 32'(8 * slot), buf_a);
        poke(32'h204 + 32'(8 * slot), 32'h0);
    endtask

    // Poll the destination read index; at the change the count must be in memory.
    task automatic wait_dst(input logic [31:0] exp, input int slot, input string tag);
        logic [31:0] v = '0;
        for (int i = 0; i < 3000; i++) begin
            reg_rd(4'd7, v);
            if (v == exp) break;
        end
        check(tag, v, exp);
        check("R9 count visible with index", 32'(mem[(32'h204 + 32'(8 * slot)) >> 2][15:0] != 0), 32'd1);
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        reg_rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset;
        expect_reg(4'd3, 32'd0, "R1 src rd");
        expect_reg(4'd7, 32'd0, "R1 dst rd");
        expect_reg(4'd10, 32'd0, "R1 pending");
        check("R1 irq", 32'(irq), 32'd0);
        expect_reg(4'd1, 32'd16, "R1 src count");
        expect_reg(4'd8, 32'h0000FFFF, "R1 maxlen");
        expect_reg(4'd11, 32'h00100000, "R1 src marks");
        expect_reg(4'd12, 32'h00100000, "R1 dst marks");
    endtask

    task automatic t_single;
        poke(32'h400, 32'h11223344);
        poke(32'h404, 32'h55667788);
        src_desc(0, 32'h400, 16'd8, 16'h0014);
        dst_desc(0, 32'h800);
        reg_wr(4'd6, 32'd1);
        reg_wr(4'd2, 32'd1);
        wait_dst(32'd1, 0, "R2 dst rd advance");
        check("R2 word0", mem[32'h800 >> 2], 32'h11223344);
        check("R2 word1", mem[32'h804 >> 2], 32'h55667788);
        check("R2 writeback", mem[32'h204 >> 2], 32'h00140008);
        expect_reg(4'd3, 32'd1, "R2 src rd");
        expect_reg(4'd10, 32'd1, "R2 pending done");
        check("R8 irq on", 32'(irq), 32'd1);
        reg_wr(4'd10, 32'd1);
        expect_reg(4'd10, 32'd0, "R8 w1c clears");
        check("R8 irq off", 32'(irq), 32'd0);
    endtask

    task automatic t_gather;
        poke(32'h440, 32'hA0A1A2A3);
        poke(32'h444, 32'hA4A5A6A7);
        poke(32'h480, 32'hB0B1B2B3);
        poke(32'h484, 32'hB4B5B6B7);
        src_desc(1, 32'h440, 16'd8, 16'h0001);
        src_desc(2, 32'h480, 16'd6, 16'h0024);
        dst_desc(1, 32'h900);
        dst_desc(2, 32'hA00);
        reg_wr(4'd6, 32'd3);
        reg_wr(4'd2, 32'd3);
        wait_dst(32'd2, 1, "R3 one completion");
        repeat (40) @(negedge clk);
        expect_reg(4'd7, 32'd2, "R3 only one dst consumed");
        expect_reg(4'd3, 32'd3, "R3 src rd");
        check("R3 seg A", mem[32'h904 >> 2], 32'hA4A5A6A7);
        check("R3 seg B", mem[32'h908 >> 2], 32'hB0B1B2B3);
        check("R3 seg B tail", mem[32'h90C >> 2], 32'hB4B5B6B7);
        check("R3 total", mem[32'h20C >> 2], 32'h0024000E);
        reg_wr(4'd10, 32'd3);
    endtask

    task automatic t_swap;
        poke(32'h4C0, 32'h01020304);
        src_desc(3, 32'h4C0, 16'd4, 16'h0006);
        reg_wr(4'd9, 32'd0);
        reg_wr(4'd2, 32'd4);
        wait_dst(32'd3, 2, "R4 dst rd");
        check("R4 swapped word", mem[32'hA00 >> 2], 32'h04030201);
        check("R4 swap flag written", mem[32'h214 >> 2], 32'h00060004);
        expect_reg(4'd3, 32'd0, "R5 src rd wraps");
        expect_reg(4'd10, 32'd1, "R8 pending while disabled");
        check("R8 irq masked", 32'(irq), 32'd0);
        reg_wr(4'd9, 32'd1);
        check("R8 irq enabled", 32'(irq), 32'd1);
        reg_wr(4'd10, 32'd1);
    endtask

    task automatic t_nodst;
        poke(32'h500, 32'hCAFEF00D);
        src_desc(0, 32'h500, 16'd4, 16'h000C);
        reg_wr(4'd2, 32'd1);
        repeat (40) @(negedge clk);
        expect_reg(4'd3, 32'd0, "R6 src not consumed");
        expect_reg(4'd7, 32'd3, "R6 dst rd held");
        dst_desc(3, 32'hB00);
        reg_wr(4'd6, 32'd0);
        wait_dst(32'd0, 3, "R5 dst rd wraps");
        check("R6 data after release", mem[32'hB00 >> 2], 32'hCAFEF00D);
        check("R6 writeback", mem[32'h21C >> 2], 32'h000C0004);
        expect_reg(4'd3, 32'd1, "R6 src rd");
        reg_wr(4'd10, 32'd3);
    endtask

    task automatic t_len;
        for (int i = 0; i < 20; i++) poke(32'h600 + 32'(4 * i), 32'h50000000 + 32'(i));
        src_desc(1, 32'h600, 16'd80, 16'h001C);
        dst_desc(0, 32'hC00);
        reg_wr(4'd6, 32'd1);
        reg_wr(4'd2, 32'd2);
        repeat (40) @(negedge clk);
        expect_reg(4'd10, 32'd2, "R7 error pending");
        expect_reg(4'd3, 32'd1, "R7 src not consumed");
        check("R7 dst count untouched", mem[32'h204 >> 2], 32'h0);
        reg_wr(4'd8, 32'd128);
        wait_dst(32'd1, 0, "R7 dst rd after raise");
        check("R7 last word", mem[32'hC4C >> 2], 32'h50000013);
        check("R7 writeback", mem[32'h204 >> 2], 32'h001C0050);
        expect_reg(4'd3, 32'd2, "R7 src rd");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        reg_wr(4'd0, 32'h100);
        reg_wr(4'd1, 32'd4);
        reg_wr(4'd4, 32'h200);
        reg_wr(4'd5, 32'd4);
        reg_wr(4'd8, 32'd64);
        reg_wr(4'd9, 32'd1);
        t_single();
        t_gather();
        t_swap();
        t_nodst();
        t_len();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule